// File: doc/BRIEF.md
# Thermal Threshold Interrupt Controller

This block watches a stream of 8-bit temperature codes and compares each accepted code against four programmable trip levels. Every level has a rising threshold and a falling threshold. A rising event is recorded when the code reaches the rising threshold. A falling event is recorded when the code drops back to the falling threshold after the level has gone hot, which gives per-level hysteresis. Events are held in a status register. A combined interrupt is raised for every status bit whose enable bit is set. Software clears status by writing ones into a clear register that has the same bit layout as the status register.

The sensor side is a valid/ready stream. The block never applies back-pressure: `samp_ready` is high in every cycle after reset, and a code is consumed on each clock edge where `samp_valid` is high. A producer may therefore present one code per cycle. There is no requirement to hold a code stable after the edge that accepts it.

A noise-cancel trip mode requires two consecutive qualifying samples before an event is recorded. An emulation override replaces the sensor code with a programmed code once a programmed delay has elapsed. A hardware trip output follows the hot state of the highest level. Registers are written with a single-cycle write strobe and read through a combinational read port.

Top module: `thermal_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, `irq` and `trip_out` are 0, and `samp_ready` is 1.
- R2: `samp_ready` stays 1 in every cycle. A code accepted while the core is enabled becomes the value of the temperature register (address 3, bits [7:0]) after that clock edge.
- R3: While control bit 0 (core enable) is 0, accepted samples change neither the temperature register nor any status bit.
- R4: The rising-threshold register (address 1) holds level i in bits [8i+7:8i]. A sample with code >= the level's rising threshold sets status bit 4i and makes the level hot. The bit is set again on every qualifying sample.
- R5: The falling-threshold register (address 2) uses the same byte layout. A sample with code <= the falling threshold of a hot level sets status bit 16+4i and makes the level cold. A level that is not hot never records a falling event. A falling threshold of 0 disables falling events for its level.
- R6: When control bits [15:13] equal 4 (noise-cancel mode), an event needs both the current sample and the previous sample to meet its comparison. In any other mode a single sample is enough.
- R7: The interrupt-enable register (address 4) uses the status layout (rising bit 4i, falling bit 16+4i). `irq` is high exactly when some status bit and its enable bit are both 1.
- R8: A write to the clear register (address 6) clears each status bit (address 5) written as 1. An event arriving in the same cycle wins over the clear. The clear register reads as 0.
- R9: `trip_out` is high when control bit 12 is 1 and level 3 is hot.
- R10: The emulation register (address 7) holds enable in bit 0, the emulated code in bits [15:8] and a delay D in bits [31:16]. A write starts a countdown from D. Samples accepted from the D+1-th clock edge after the write onward use the emulated code in place of the sensor code. While the enable bit is 0, the sensor code is used.
- R11: The register addresses are 0 control, 1 rising thresholds, 2 falling thresholds, 3 temperature (read-only), 4 interrupt enable, 5 status (read-only), 6 clear (write-only), 7 emulation. Control reads back bits 0, 12 and [15:13] only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_valid | input | 1 | Sensor code present |
| samp_ready | output | 1 | Block accepts a code (always 1 after reset) |
| samp_code | input | 8 | Sensor temperature code |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Combined interrupt |
| trip_out | output | 1 | Hardware over-temperature trip |

## Verification
The bench builds the block with its default parameters: four levels, 8-bit codes and a 16-bit delay field. These defaults place every status bit at the positions software sees, so each level's rising and falling bits can be checked by exact word compares. Because the delay comes from the written register rather than from a parameter, short values such as 0 and 3 reach both the immediate emulation case and the countdown case within a few cycles. The same build covers noise-cancel qualification, hysteresis across levels and the clear-versus-event collision.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_RISE = 3'd1,
    A_FALL = 3'd2,
    A_TEMP = 3'd3,
    A_IEN  = 3'd4,
    A_STAT = 3'd5,
    A_CLR  = 3'd6,
    A_EMUL = 3'd7
  } reg_addr_e;

  // control field positions (software-visible)
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_TRIP_BIT = 12;
  localparam int CTRL_MODE_LSB = 13;
  localparam int MODE_W        = 3;
  localparam logic [MODE_W-1:0] MODE_NOISE_CANCEL = 3'd4;

  // event bit placement in enable / status / clear words
  localparam int EV_STRIDE = 4;
  localparam int FALL_BASE = 16;

  // emulation field positions
  localparam int EM_EN_BIT   = 0;
  localparam int EM_CODE_LSB = 8;
  localparam int EM_DLY_LSB  = 16;
endpackage

// File: rtl/thr_level.sv
module thr_level #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              nc_mode,
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] rise_thr,
  input  logic [CODE_W-1:0] fall_thr,
  output logic              rise_ev,
  output logic              fall_ev,
  output logic              hot
);
  logic rise_met, fall_met, rise_ok, fall_ok;
  logic rise_prev_q, fall_prev_q, hot_q;

  assign rise_met = (code >= rise_thr);
  assign fall_met = (fall_thr != '0) && (code <= fall_thr);
  assign rise_ok  = rise_met && (!nc_mode || rise_prev_q);
  assign fall_ok  = fall_met && hot_q && (!nc_mode || fall_prev_q);

  assign rise_ev = fire && rise_ok;
  assign fall_ev = fire && fall_ok && !rise_ok;
  assign hot     = hot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_prev_q <= 1'b0;
      fall_prev_q <= 1'b0;
      hot_q       <= 1'b0;
    end else if (fire) begin
      rise_prev_q <= rise_met;
      fall_prev_q <= fall_met;
      if (rise_ok)      hot_q <= 1'b1;
      else if (fall_ok) hot_q <= 1'b0;
    end
  end
endmodule

// File: rtl/thr_emul.sv
module thr_emul #(
  parameter int CODE_W = 8,
  parameter int DLY_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DLY_W-1:0]  load_dly,
  input  logic              en,
  input  logic [CODE_W-1:0] emu_code,
  input  logic [CODE_W-1:0] sens_code,
  output logic [CODE_W-1:0] eff_code,
  output logic              active
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_dly;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign active   = en && (cnt_q == '0);
  assign eff_code = active ? emu_code : sens_code;

  // R10
  emul_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_dly != '0) |=> !active);
endmodule

// File: rtl/thr_regs.sv
module thr_regs
  import thr_pkg::*;
#(
  parameter int NLVL   = 4,
  parameter int CODE_W = 8,
  parameter int DLY_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [DATA_W-1:0]      rdata,
  input  logic [NLVL-1:0]        rise_set,
  input  logic [NLVL-1:0]        fall_set,
  input  logic                   temp_upd,
  input  logic [CODE_W-1:0]      temp_code,
  output logic                   core_en,
  output logic                   trip_en,
  output logic [MODE_W-1:0]      mode,
  output logic [NLVL*CODE_W-1:0] rise_thr,
  output logic [NLVL*CODE_W-1:0] fall_thr,
  output logic [NLVL-1:0]        rise_ien,
  output logic [NLVL-1:0]        fall_ien,
  output logic [NLVL-1:0]        rise_st,
  output logic [NLVL-1:0]        fall_st,
  output logic                   em_en,
  output logic [CODE_W-1:0]      em_code,
  output logic [DLY_W-1:0]       em_dly
);
  localparam int THR_W = NLVL * CODE_W;

  logic [NLVL-1:0] clr_rise, clr_fall;
  logic            clr_hit;
  logic [DATA_W-1:0] ien_word, st_word, ctrl_word, emul_word;

  assign clr_hit = we && (addr == A_CLR);

  always_comb begin
    for (int i = 0; i < NLVL; i++) begin
      clr_rise[i] = clr_hit && wdata[EV_STRIDE*i];
      clr_fall[i] = clr_hit && wdata[FALL_BASE+EV_STRIDE*i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_en  <= 1'b0;
      trip_en  <= 1'b0;
      mode     <= '0;
      rise_thr <= '0;
      fall_thr <= '0;
      rise_ien <= '0;
      fall_ien <= '0;
      em_en    <= 1'b0;
      em_code  <= '0;
      em_dly   <= '0;
    end else if (we) begin
      case (addr)
        A_CTRL: begin
          core_en <= wdata[CTRL_EN_BIT];
          trip_en <= wdata[CTRL_TRIP_BIT];
          mode    <= wdata[CTRL_MODE_LSB +: MODE_W];
        end
        A_RISE: rise_thr <= wdata[THR_W-1:0];
        A_FALL: fall_thr <= wdata[THR_W-1:0];
        A_IEN: begin
          for (int i = 0; i < NLVL; i++) begin
            rise_ien[i] <= wdata[EV_STRIDE*i];
            fall_ien[i] <= wdata[FALL_BASE+EV_STRIDE*i];
          end
        end
        A_EMUL: begin
          em_en   <= wdata[EM_EN_BIT];
          em_code <= wdata[EM_CODE_LSB +: CODE_W];
          em_dly  <= wdata[EM_DLY_LSB +: DLY_W];
        end
        default: ;
      endcase
    end
  end

  logic [CODE_W-1:0] temp_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        temp_q <= '0;
    else if (temp_upd) temp_q <= temp_code;
  end

  // event set wins over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_st <= '0;
      fall_st <= '0;
    end else begin
      rise_st <= rise_set | (rise_st & ~clr_rise);
      fall_st <= fall_set | (fall_st & ~clr_fall);
    end
  end

  always_comb begin
    ien_word  = '0;
    st_word   = '0;
    ctrl_word = '0;
    emul_word = '0;
    for (int i = 0; i < NLVL; i++) begin
      ien_word[EV_STRIDE*i]           = rise_ien[i];
      ien_word[FALL_BASE+EV_STRIDE*i] = fall_ien[i];
      st_word[EV_STRIDE*i]            = rise_st[i];
      st_word[FALL_BASE+EV_STRIDE*i]  = fall_st[i];
    end
    ctrl_word[CTRL_EN_BIT]                = core_en;
    ctrl_word[CTRL_TRIP_BIT]              = trip_en;
    ctrl_word[CTRL_MODE_LSB +: MODE_W]    = mode;
    emul_word[EM_EN_BIT]                  = em_en;
    emul_word[EM_CODE_LSB +: CODE_W]      = em_code;
    emul_word[EM_DLY_LSB +: DLY_W]        = em_dly;
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = ctrl_word;
      A_RISE:  rdata = DATA_W'(rise_thr);
      A_FALL:  rdata = DATA_W'(fall_thr);
      A_TEMP:  rdata = DATA_W'(temp_q);
      A_IEN:   rdata = ien_word;
      A_STAT:  rdata = st_word;
      A_EMUL:  rdata = emul_word;
      default: rdata = '0;
    endcase
  end

  generate
    for (genvar g = 0; g < NLVL; g++) begin : g_clr_chk
      // R8
      clr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rise[g] && !rise_set[g]) |=> !rise_st[g]);
      // R8
      clr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_fall[g] && !fall_set[g]) |=> !fall_st[g]);
    end
  endgenerate
endmodule

// File: rtl/thermal_irq_ctrl.sv
module thermal_irq_ctrl
  import thr_pkg::*;
#(
  parameter int NLVL   = 4,
  parameter int CODE_W = 8,
  parameter int DLY_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_valid,
  output logic              samp_ready,
  input  logic [CODE_W-1:0] samp_code,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              trip_out
);
  localparam int THR_W = NLVL * CODE_W;
  localparam int TOP_LVL = NLVL - 1;

  logic              core_en, trip_en, em_en, em_active, fire, nc_mode;
  logic [MODE_W-1:0] mode;
  logic [THR_W-1:0]  rise_thr, fall_thr;
  logic [NLVL-1:0]   rise_ien, fall_ien, rise_st, fall_st;
  logic [NLVL-1:0]   rise_ev, fall_ev, hot;
  logic [CODE_W-1:0] em_code, eff_code;
  logic [DLY_W-1:0]  em_dly;
  logic              em_load, clr_hit;
  logic              rdy_q;

  // no back-pressure: ready rises after reset and stays high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end
  assign samp_ready = rdy_q | rst_n;

  assign fire    = samp_valid && samp_ready && core_en;
  assign nc_mode = (mode == MODE_NOISE_CANCEL);
  assign em_load = reg_we && (reg_addr == A_EMUL);
  assign clr_hit = reg_we && (reg_addr == A_CLR);

  thr_regs #(.NLVL(NLVL), .CODE_W(CODE_W), .DLY_W(DLY_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .rise_set(rise_ev), .fall_set(fall_ev),
    .temp_upd(fire), .temp_code(eff_code),
    .core_en(core_en), .trip_en(trip_en), .mode(mode),
    .rise_thr(rise_thr), .fall_thr(fall_thr),
    .rise_ien(rise_ien), .fall_ien(fall_ien),
    .rise_st(rise_st), .fall_st(fall_st),
    .em_en(em_en), .em_code(em_code), .em_dly(em_dly)
  );

  thr_emul #(.CODE_W(CODE_W), .DLY_W(DLY_W)) u_emul (
    .clk(clk), .rst_n(rst_n),
    .load(em_load), .load_dly(reg_wdata[EM_DLY_LSB +: DLY_W]),
    .en(em_en), .emu_code(em_code), .sens_code(samp_code),
    .eff_code(eff_code), .active(em_active)
  );

  generate
    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
      thr_level #(.CODE_W(CODE_W)) u_lvl (
        .clk(clk), .rst_n(rst_n),
        .fire(fire), .nc_mode(nc_mode), .code(eff_code),
        .rise_thr(rise_thr[g*CODE_W +: CODE_W]),
        .fall_thr(fall_thr[g*CODE_W +: CODE_W]),
        .rise_ev(rise_ev[g]), .fall_ev(fall_ev[g]), .hot(hot[g])
      );

      // R5
      fall_after_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fall_st[g]) |-> $past(hot[g]));
    end
  endgenerate

  assign irq      = |((rise_st & rise_ien) | (fall_st & fall_ien));
  assign trip_out = trip_en && hot[TOP_LVL];

  // R3
  core_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_en && !clr_hit) |=> $stable({rise_st, fall_st}));

  // R9
  trip_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hot[TOP_LVL]) && !em_active) |-> $past(samp_valid && core_en));
endmodule

// File: tb/sim_thermal_irq_ctrl.sv
module sim_thermal_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        samp_valid = 1'b0;
  logic        samp_ready;
  logic [7:0]  samp_code = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq, trip_out;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  thermal_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .samp_valid(samp_valid), .samp_ready(samp_ready), .samp_code(samp_code),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .trip_out(trip_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic samp(input logic [7:0] c);
    @(negedge clk);
    samp_valid = 1'b1; samp_code = c;
    @(negedge clk);
    samp_valid = 1'b0;
  endtask

  task automatic wr_samp(input logic [2:0] a, input logic [31:0] d, input logic [7:0] c);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    samp_valid = 1'b1; samp_code = c;
    @(negedge clk);
    reg_we = 1'b0; samp_valid = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 reg reset", d, 32'h0);
    end
    check("R1 irq reset", {31'b0, irq}, 32'h0);
    check("R1 trip reset", {31'b0, trip_out}, 32'h0);
    check("R1 ready", {31'b0, samp_ready}, 32'h1);
  endtask

  task automatic t_setup_disabled();
    logic [31:0] d;
    wr(3'd1, 32'h5A50463C);
    wr(3'd2, 32'h554B4137);
    wr(3'd4, 32'hFFFFFFFF);
    rd(3'd1, d); check("R4 R11 rise layout", d, 32'h5A50463C);
    rd(3'd4, d); check("R7 R11 enable readback", d, 32'h11111111);
    samp(8'd100);
    rd(3'd3, d); check("R3 temp unchanged when off", d, 32'h0);
    rd(3'd5, d); check("R3 no event when off", d, 32'h0);
  endtask

  task automatic t_rise_fall();
    logic [31:0] d;
    wr(3'd0, 32'h1);
    rd(3'd0, d); check("R11 ctrl readback", d, 32'h1);
    samp(8'd72);
    rd(3'd3, d); check("R2 temp follows sample", d, 32'd72);
    rd(3'd5, d); check("R4 rise levels 0,1", d, 32'h00000011);
    check("R7 irq on enabled status", {31'b0, irq}, 32'h1);
    check("R2 ready steady", {31'b0, samp_ready}, 32'h1);
    samp(8'd64);
    rd(3'd5, d); check("R5 fall level1 only hot levels", d, 32'h00100011);
  endtask

  task automatic t_clear_mask();
    logic [31:0] d;
    wr(3'd6, 32'hFFFFFFFF);
    rd(3'd5, d); check("R8 clear all", d, 32'h0);
    rd(3'd6, d); check("R8 clear reads zero", d, 32'h0);
    check("R7 irq low after clear", {31'b0, irq}, 32'h0);
    wr(3'd4, 32'h11110000);
    samp(8'd64);
    rd(3'd5, d); check("R4 rise level0 again", d, 32'h1);
    check("R7 masked status no irq", {31'b0, irq}, 32'h0);
    wr(3'd4, 32'hFFFFFFFF);
    wr_samp(3'd6, 32'h1, 8'd64);
    rd(3'd5, d); check("R8 set wins over clear", d, 32'h1);
    wr(3'd6, 32'h1);
    rd(3'd5, d); check("R8 clear single bit", d, 32'h0);
  endtask

  task automatic t_fall_zero();
    logic [31:0] d;
    wr(3'd2, 32'h554B4100);
    samp(8'd10);
    rd(3'd5, d); check("R5 zero fall threshold disables", d, 32'h0);
  endtask

  task automatic t_noise();
    logic [31:0] d;
    wr(3'd0, 32'h8001);
    samp(8'd75);
    rd(3'd5, d); check("R6 one sample not enough", d, 32'h0);
    samp(8'd75);
    rd(3'd5, d); check("R6 two samples rise", d, 32'h11);
    wr(3'd6, 32'hFFFFFFFF);
    samp(8'd62);
    rd(3'd5, d); check("R6 one low sample no fall", d & 32'h00100000, 32'h0);
    samp(8'd62);
    rd(3'd5, d); check("R6 two low samples fall", d & 32'h00100000, 32'h00100000);
  endtask

  task automatic t_trip();
    wr(3'd0, 32'h1001);
    check("R9 trip idle", {31'b0, trip_out}, 32'h0);
    samp(8'd95);
    check("R9 trip on hot level3", {31'b0, trip_out}, 32'h1);
    samp(8'd80);
    check("R9 trip off after fall", {31'b0, trip_out}, 32'h0);
    wr(3'd0, 32'h1);
    samp(8'd95);
    check("R9 trip gated by enable", {31'b0, trip_out}, 32'h0);
    wr(3'd0, 32'h1001);
    check("R9 trip shows held hot", {31'b0, trip_out}, 32'h1);
    samp(8'd80);
  endtask

  task automatic t_emul();
    logic [31:0] d;
    wr(3'd0, 32'h1);
    wr(3'd7, 32'h00036401);
    rd(3'd7, d); check("R10 emul readback", d, 32'h00036401);
    samp(8'd40);
    rd(3'd3, d); check("R10 sensor used during delay", d, 32'd40);
    repeat (4) @(negedge clk);
    samp(8'd40);
    rd(3'd3, d); check("R10 emulated code after delay", d, 32'd100);
    wr(3'd7, 32'h0);
    samp(8'd41);
    rd(3'd3, d); check("R10 sensor after disable", d, 32'd41);
    wr(3'd7, 32'h00005001);
    samp(8'd30);
    rd(3'd3, d); check("R10 zero delay immediate", d, 32'd80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup_disabled();
    t_rise_fall();
    t_clear_mask();
    t_fall_zero();
    t_noise();
    t_trip();
    t_emul();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule